// File: doc/BRIEF.md
# Tuner Reset Source Selector with Boot Strap Capture

This block decides what drives the reset line of an external tuner and that line's output enable. Three sources compete. Software can take the line over through a control register. Failing that, the boot-sequencing module supplies a select input. That select picks either the module's live reset and output-enable pair, or a held copy of that pair. The held copy follows the live pair while the module runs and freezes while the module is itself in reset. The tuner therefore keeps a stable reset state while its usual master is down.

The same register also records two boot strap pins. It captures them on the first cycle in which strap-done is seen after reset. It drives a boot-from-flash signal to the boot module. That signal passes raw strap pin 0 through until the capture, and from then on it drives the captured bit 0. Writes to the software fields are protected by a two-key scheme outside the block, which reaches this block as a single unlock input.

Top module: `tuner_rst_ctrl`

## Requirements
- R1: After reset every implemented register bit is 0, so `rdData` reads 0.
- R2: Bits 31:16, 13:11 and 7:2 of `rdData` always read 0, even after a write of all ones.
- R3: A write updates bits 10:8 (bit 8 = software select, bit 9 = software reset level, bit 10 = software output enable) on the next clock edge. It takes effect only when `wrEn` is high, `wrAddr` equals offset 0x004 and `unlock` is high. Any other write leaves the register unchanged.
- R4: While bit 8 is 1, `tunerRst` equals bit 9 and `tunerRstOe` equals bit 10, whatever the module-side inputs are.
- R5: While bit 8 is 0 and `modSel` is 0, `tunerRst` and `tunerRstOe` follow the live `modRst` and `modRstOe` inputs combinationally.
- R6: While bit 8 is 0 and `modSel` is 1, `tunerRst` equals held bit 15 and `tunerRstOe` equals held bit 14.
- R7: At each clock edge where `modInReset` is 0, bit 15 takes `modRst` and bit 14 takes `modRstOe`. At edges where `modInReset` is 1, both bits hold their value. Software writes never change them.
- R8: Bits 1:0 take `strapPins` at the first clock edge after reset where `strapDone` is 1. Later `strapDone` pulses and software writes do not change them.
- R9: Before that capture edge, `bootFromFlash` equals `strapPins[0]`. After it, `bootFromFlash` equals captured bit 0 and ignores the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 12 | Register write offset |
| wrData | input | 32 | Register write data |
| unlock | input | 1 | High when the external key sequence has opened writes |
| modRst | input | 1 | Tuner reset level from the boot module |
| modRstOe | input | 1 | Tuner reset output enable from the boot module |
| modSel | input | 1 | Boot-module choice: 0 live pair, 1 held pair |
| modInReset | input | 1 | High while the boot module is itself held in reset |
| strapPins | input | 2 | Raw boot strap pins |
| strapDone | input | 1 | Strap sampling window is valid |
| tunerRst | output | 1 | Reset level driven to the tuner |
| tunerRstOe | output | 1 | Output enable for the tuner reset pad |
| bootFromFlash | output | 1 | Boot-from-flash indication to the boot module |
| rdData | output | 32 | Current register contents |

## Verification
The hardest case to reach from the ports is the held-pair path. Its bits only differ from the live inputs after the module has been put into reset and the live pair has then moved. The stimulus loads a known pair with `modInReset` low for one edge. It then raises `modInReset`, drives a different live pair and performs the register write in the same window. The checks then tell the held, live and software sources apart. The once-only strap capture is reached the same way: a second `strapDone` pulse is given with different pin values, and the test confirms that neither the readback nor `bootFromFlash` moves.

// File: rtl/tuner_rst_pkg.sv
package tuner_rst_pkg;

  // Register field positions inside the control word
  localparam int BIT_SW_SEL  = 8;
  localparam int BIT_SW_RST  = 9;
  localparam int BIT_SW_OE   = 10;
  localparam int BIT_HOLD_OE = 14;
  localparam int BIT_HOLD_RST = 15;
  localparam int STRAP_W     = 2;

  // Software override fields
  typedef struct packed {
    logic oe;
    logic rst;
    logic sel;
  } swCfg_t;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic swWrite;
    logic holdCapture;
    logic strapCapture;
  } ctrlStrobes_t;

endpackage

// File: rtl/tuner_rst_ctl.sv
module tuner_rst_ctl
  import tuner_rst_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter logic [11:0] REG_OFFSET = 12'h004
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              unlock,
  input  logic              modInReset,
  input  logic              strapDone,
  output ctrlStrobes_t      strobes,
  output logic              strapTaken
);

  localparam logic [ADDR_W-1:0] OFFSET_CMP = ADDR_W'(REG_OFFSET);

  logic addrHit;

  assign addrHit = (wrAddr == OFFSET_CMP);

  always_comb begin
    strobes              = '0;
    strobes.swWrite      = wrEn && addrHit && unlock;
    strobes.holdCapture  = !modInReset;
    strobes.strapCapture = strapDone && !strapTaken;
  end

  // Sticky flag: strap bits are taken once per reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapTaken <= 1'b0;
    end else if (strobes.strapCapture) begin
      strapTaken <= 1'b1;
    end
  end

endmodule

// File: rtl/tuner_rst_dp.sv
module tuner_rst_dp
  import tuner_rst_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic               strapTaken,
  input  swCfg_t             wrCfg,
  input  logic               modRst,
  input  logic               modRstOe,
  input  logic               modSel,
  input  logic [STRAP_W-1:0] strapPins,
  output logic               tunerRst,
  output logic               tunerRstOe,
  output logic               bootFromFlash,
  output logic [DATA_W-1:0]  rdData
);

  swCfg_t             swCfg;
  logic               holdRst;
  logic               holdOe;
  logic [STRAP_W-1:0] strapLat;

  // Software override fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swCfg <= '0;
    end else if (strobes.swWrite) begin
      swCfg <= wrCfg;
    end
  end

  // Held copy of the module-side pair, frozen while the module is in reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdRst <= 1'b0;
      holdOe  <= 1'b0;
    end else if (strobes.holdCapture) begin
      holdRst <= modRst;
      holdOe  <= modRstOe;
    end
  end

  // One capture flop per strap bit
  for (genvar gi = 0; gi < STRAP_W; gi++) begin : g_strap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        strapLat[gi] <= 1'b0;
      end else if (strobes.strapCapture) begin
        strapLat[gi] <= strapPins[gi];
      end
    end
  end

  // Three-way source selection, software first
  always_comb begin
    if (swCfg.sel) begin
      tunerRst   = swCfg.rst;
      tunerRstOe = swCfg.oe;
    end else if (modSel) begin
      tunerRst   = holdRst;
      tunerRstOe = holdOe;
    end else begin
      tunerRst   = modRst;
      tunerRstOe = modRstOe;
    end
  end

  assign bootFromFlash = strapTaken ? strapLat[0] : strapPins[0];

  always_comb begin
    rdData                   = '0;
    rdData[BIT_SW_SEL]       = swCfg.sel;
    rdData[BIT_SW_RST]       = swCfg.rst;
    rdData[BIT_SW_OE]        = swCfg.oe;
    rdData[BIT_HOLD_OE]      = holdOe;
    rdData[BIT_HOLD_RST]     = holdRst;
    rdData[STRAP_W-1:0]      = strapLat;
  end

endmodule

// File: rtl/tuner_rst_ctrl.sv
module tuner_rst_ctrl
  import tuner_rst_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 12,
  parameter logic [11:0] REG_OFFSET = 12'h004
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              unlock,
  input  logic              modRst,
  input  logic              modRstOe,
  input  logic              modSel,
  input  logic              modInReset,
  input  logic [1:0]        strapPins,
  input  logic              strapDone,
  output logic              tunerRst,
  output logic              tunerRstOe,
  output logic              bootFromFlash,
  output logic [DATA_W-1:0] rdData
);

  ctrlStrobes_t strobes;
  logic         strapTaken;
  swCfg_t       wrCfg;
  logic         unusedWrBits;

  assign wrCfg.sel    = wrData[BIT_SW_SEL];
  assign wrCfg.rst    = wrData[BIT_SW_RST];
  assign wrCfg.oe     = wrData[BIT_SW_OE];
  assign unusedWrBits = ^{wrData[DATA_W-1:BIT_SW_OE+1], wrData[BIT_SW_SEL-1:0]};

  tuner_rst_ctl #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
  ) i_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .unlock     (unlock),
    .modInReset (modInReset),
    .strapDone  (strapDone),
    .strobes    (strobes),
    .strapTaken (strapTaken)
  );

  tuner_rst_dp #(
    .DATA_W (DATA_W)
  ) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .strapTaken    (strapTaken),
    .wrCfg         (wrCfg),
    .modRst        (modRst),
    .modRstOe      (modRstOe),
    .modSel        (modSel),
    .strapPins     (strapPins),
    .tunerRst      (tunerRst),
    .tunerRstOe    (tunerRstOe),
    .bootFromFlash (bootFromFlash),
    .rdData        (rdData)
  );

endmodule

// File: rtl/tuner_rst_chk.sv
module tuner_rst_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       unlock,
  input logic       modRst,
  input logic       modRstOe,
  input logic       modSel,
  input logic       modInReset,
  input logic       strapPin0,
  input logic       strapDone,
  input logic       tunerRst,
  input logic       tunerRstOe,
  input logic       bootFromFlash,
  input logic [1:0] holdBits,
  input logic [2:0] cfgBits,
  input logic [1:0] strapBits
);

  logic seenDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenDone <= 1'b0;
    else if (strapDone) seenDone <= 1'b1;
  end

  // R3
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !unlock) |=> $stable(cfgBits));

  // R4
  sw_override_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgBits[0] |-> (tunerRst == cfgBits[1] && tunerRstOe == cfgBits[2]));

  // R5
  live_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgBits[0] && !modSel) |-> (tunerRst == modRst && tunerRstOe == modRstOe));

  // R6
  held_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgBits[0] && modSel) |-> (tunerRst == holdBits[1] && tunerRstOe == holdBits[0]));

  // R7
  hold_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modInReset |=> (holdBits == $past({modRst, modRstOe})));

  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    modInReset |=> $stable(holdBits));

  // R8
  strap_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    seenDone |=> $stable(strapBits));

  // R9
  boot_raw_chk: assert property (@(posedge clk) disable iff (!rstN)
    !seenDone |-> (bootFromFlash == strapPin0));

  // R9
  boot_latched_chk: assert property (@(posedge clk) disable iff (!rstN)
    seenDone |-> (bootFromFlash == strapBits[0]));

endmodule

bind tuner_rst_ctrl tuner_rst_chk i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .wrEn          (wrEn),
  .unlock        (unlock),
  .modRst        (modRst),
  .modRstOe      (modRstOe),
  .modSel        (modSel),
  .modInReset    (modInReset),
  .strapPin0     (strapPins[0]),
  .strapDone     (strapDone),
  .tunerRst      (tunerRst),
  .tunerRstOe    (tunerRstOe),
  .bootFromFlash (bootFromFlash),
  .holdBits      (rdData[15:14]),
  .cfgBits       (rdData[10:8]),
  .strapBits     (rdData[1:0])
);

// File: tb/test_tuner_rst_ctrl.sv
module test_tuner_rst_ctrl;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 8;

  // [9:7] cfg {oe,rst,sel}, 6 modSel, 5 holdRst, 4 holdOe,
  // 3 liveRst, 2 liveOe, 1 expRst, 0 expOe
  localparam logic [9:0] VECS [0:NVEC-1] = '{
    10'b001_0_11_11_00,
    10'b011_1_00_11_10,
    10'b101_0_11_00_01,
    10'b111_1_00_00_11,
    10'b000_0_11_01_01,
    10'b110_0_00_10_10,
    10'b000_1_10_01_10,
    10'b110_1_01_10_01
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        unlock = 1'b0;
  logic        modRst = 1'b0;
  logic        modRstOe = 1'b0;
  logic        modSel = 1'b0;
  logic        modInReset = 1'b1;
  logic [1:0]  strapPins = 2'b00;
  logic        strapDone = 1'b0;
  logic        tunerRst;
  logic        tunerRstOe;
  logic        bootFromFlash;
  logic [31:0] rdData;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tuner_rst_ctrl i_tuner_rst_ctrl (
    .clk (clk), .rstN (rstN), .wrEn (wrEn), .wrAddr (wrAddr), .wrData (wrData),
    .unlock (unlock), .modRst (modRst), .modRstOe (modRstOe), .modSel (modSel),
    .modInReset (modInReset), .strapPins (strapPins), .strapDone (strapDone),
    .tunerRst (tunerRst), .tunerRstOe (tunerRstOe),
    .bootFromFlash (bootFromFlash), .rdData (rdData)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d, input logic key);
    wrEn = 1'b1; wrAddr = a; wrData = d; unlock = key;
    tick();
    wrEn = 1'b0; wrData = '0; unlock = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();

    // R1: reset state, live path with zero inputs
    check("R1 rdData", rdData, 32'h0);
    check("R5 tunerRst live zero", {31'b0, tunerRst}, 32'h0);
    check("R5 tunerRstOe live zero", {31'b0, tunerRstOe}, 32'h0);

    // R3: locked and misaddressed writes ignored
    regWrite(12'h004, 32'hFFFF_FFFF, 1'b0);
    check("R3 locked write", rdData, 32'h0);
    regWrite(12'h008, 32'hFFFF_FFFF, 1'b1);
    check("R3 wrong address", rdData, 32'h0);

    // R2/R3: all-ones write only sets bits 10:8
    regWrite(12'h004, 32'hFFFF_FFFF, 1'b1);
    check("R2 reserved zero", rdData, 32'h0000_0700);
    check("R4 override rst", {31'b0, tunerRst}, 32'h1);
    check("R4 override oe", {31'b0, tunerRstOe}, 32'h1);
    modRst = 1'b0; modRstOe = 1'b0; #1;
    check("R4 override ignores module", {30'b0, tunerRst, tunerRstOe}, 32'h3);
    regWrite(12'h004, 32'h0, 1'b1);

    // R9: raw pin passes through before capture
    strapPins = 2'b10; #1;
    check("R9 raw pin 0", {31'b0, bootFromFlash}, 32'h0);
    strapPins = 2'b01; #1;
    check("R9 raw pin 1", {31'b0, bootFromFlash}, 32'h1);

    // R8: capture on strapDone
    strapDone = 1'b1;
    tick();
    strapDone = 1'b0;
    check("R8 captured", {30'b0, rdData[1:0]}, 32'h1);
    strapPins = 2'b10; #1;
    check("R9 latched after capture", {31'b0, bootFromFlash}, 32'h1);
    strapDone = 1'b1;
    tick();
    strapDone = 1'b0;
    check("R8 no recapture", {30'b0, rdData[1:0]}, 32'h1);
    regWrite(12'h004, 32'h0000_0002, 1'b1);
    check("R8 write ignored", {30'b0, rdData[1:0]}, 32'h1);

    // R4/R5/R6/R7: source selection table
    for (int i = 0; i < NVEC; i++) begin
      logic [9:0] v;
      v = VECS[i];
      modInReset = 1'b0; modRst = v[5]; modRstOe = v[4];
      tick();
      modInReset = 1'b1; modRst = v[3]; modRstOe = v[2]; modSel = v[6];
      regWrite(12'h004, {21'b0, v[9:7], 8'b0}, 1'b1);
      check("R3 cfg bits", {29'b0, rdData[10:8]}, {29'b0, v[9:7]});
      check("R7 held pair", {30'b0, rdData[15:14]}, {30'b0, v[5:4]});
      check(v[7] ? "R4 output" : (v[6] ? "R6 output" : "R5 output"),
            {30'b0, tunerRst, tunerRstOe}, {30'b0, v[1:0]});
    end

    // R7: frozen across several cycles of module reset
    regWrite(12'h004, 32'h0, 1'b1);
    modInReset = 1'b0; modRst = 1'b1; modRstOe = 1'b0;
    tick();
    modInReset = 1'b1;
    for (int k = 0; k < 4; k++) begin
      modRst = k[0]; modRstOe = ~k[0];
      tick();
    end
    check("R7 freeze", {30'b0, rdData[15:14]}, 32'h2);
    modSel = 1'b1; #1;
    check("R6 held during freeze", {30'b0, tunerRst, tunerRstOe}, 32'h2);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule